// File: doc/BRIEF.md
# Linear CCD Drive Clock Sequencer

This block produces the full set of drive clocks for a three-colour linear CCD whose rows are read out through shift registers on both sides. Each line starts with a quiet gap, a single transfer-gate pulse that moves charge from all three colour rows at once, and a second quiet gap. It then streams a fixed number of pixels. Each pixel is one period of the reset-gate clock. Because the two readout registers are interleaved, the shift clocks toggle once per pixel, so they run at half the pixel rate.

All durations are counted in system-clock cycles and come from input words. The block raises any value below its legal floor to that floor. It samples the words, and the clamp mode, once at the start of each line. In per-pixel clamp mode the clamp clock pulses in every pixel just after the reset gate. In per-line clamp mode the clamp clock is the inverse of the transfer pulse. Each pixel is tagged with a class code and an index, and a strobe marks the first shift edge of every line. While `run_en` stays high, lines follow one another with no gap between them. When it drops, the current line finishes and the block goes idle.

Top module: `ccd_timing_gen`

## Requirements
- R1: After the synchronous active-high reset and while idle: `tg`=0, `rb`=1, `phi1`=`phi1l`=1, `phi2`=`phi2l`=0, `clb`=1, `line_start`=0, `pix_class`=0 and `pix_idx`=0.
- R2: If `run_en` is high at an edge while idle, a line begins on that edge. A line is G gap cycles, then T cycles with `tg` high, then G gap cycles, then NPIX=OB+2*INV+VALID pixels of P cycles each, giving a period of 2G+T+NPIX*P. If `run_en` is high at the last cycle of a line, the next line follows at once; if it is low, the block returns to idle.
- R3: The block uses T=max(`tg_width`,TG_MIN), G=max(`gap_width`,GAP_MIN) and P=max(`pix_period`,PIX_MIN). The reset width R is 1 if `rb_width` is 0, floor(P/2) if `rb_width` exceeds floor(P/2), and `rb_width` otherwise.
- R4: The duration words and `clamp_mode` are captured on the edge that starts a line. Changes made later in that line take effect only from the next line.
- R5: Outside the pixel stream `phi1` is 1 and `phi2` is 0. During pixel k, `phi1` equals bit 0 of k. `phi2` is always the inverse of `phi1`, and `phi1l` and `phi2l` always equal `phi1` and `phi2`.
- R6: `rb` is 1 outside the pixel stream, including the whole transfer pulse. Inside a pixel it is 1 for the first R cycles and 0 for the rest.
- R7: With `clamp_mode`=0 (per-pixel clamp), `clb` is 1 outside the pixel stream. Inside a pixel it is 1 exactly in cycles R to 2R-1.
- R8: With `clamp_mode`=1 (per-line clamp), `clb` is always the inverse of `tg`.
- R9: `pix_class` is 2'b01 (optical black) for pixels 0..OB-1, 2'b10 (invalid) for the next INV pixels and for the last INV pixels, 2'b11 (valid) for the VALID pixels between them, and 2'b00 outside the pixel stream.
- R10: `pix_idx` is k throughout pixel k and 0 outside the pixel stream.
- R11: `line_start` is 1 for exactly the first cycle of pixel 0 of each line and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start and keep running lines |
| clamp_mode | input | 1 | 0 per-pixel clamp, 1 per-line clamp |
| tg_width | input | W | Transfer pulse length in cycles |
| gap_width | input | W | Quiet gap on each side of the pulse |
| pix_period | input | W | Cycles per pixel |
| rb_width | input | W | Reset-gate high cycles per pixel |
| tg | output | 1 | Transfer-gate clock shared by all colour rows |
| phi1 | output | 1 | Shift clock phase 1 |
| phi2 | output | 1 | Shift clock phase 2 |
| phi1l | output | 1 | Last-stage shift clock phase 1 |
| phi2l | output | 1 | Last-stage shift clock phase 2 |
| rb | output | 1 | Reset-gate clock |
| clb | output | 1 | Clamp clock |
| line_start | output | 1 | First shift edge of a line |
| pix_class | output | 2 | Class of the current pixel |
| pix_idx | output | IW | Index of the current pixel |

## Verification
Every output is decoded from the state registers without further delay. A line therefore begins one edge after `run_en` is seen high in idle, and the first gap cycle is visible right after that edge. The bench raises `run_en` on a falling edge. It then checks every output on each later falling edge against an arithmetic model of the line position, 2G+T+NPIX*P cycles per line, so each result is sampled in the cycle it is due. To check R4, inputs changed partway through a line are expected to show their effect only in the following line. Idle is checked on the falling edge after the last pixel cycle.

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
  parameter int W       = 16,
  parameter int OB      = 48,
  parameter int INV     = 4,
  parameter int VALID   = 21360,
  parameter int TG_MIN  = 500,
  parameter int GAP_MIN = 90,
  parameter int PIX_MIN = 4,
  localparam int NPIX   = OB + 2*INV + VALID,
  localparam int IW     = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          clamp_mode,
  input  logic [W-1:0]  tg_width,
  input  logic [W-1:0]  gap_width,
  input  logic [W-1:0]  pix_period,
  input  logic [W-1:0]  rb_width,
  output logic          tg,
  output logic          phi1,
  output logic          phi2,
  output logic          phi1l,
  output logic          phi2l,
  output logic          rb,
  output logic          clb,
  output logic          line_start,
  output logic [1:0]    pix_class,
  output logic [IW-1:0] pix_idx
);
  localparam logic [W-1:0]  TGM  = W'(TG_MIN);
  localparam logic [W-1:0]  GPM  = W'(GAP_MIN);
  localparam logic [W-1:0]  PXM  = W'(PIX_MIN);
  localparam logic [IW-1:0] E_OB = IW'(OB);
  localparam logic [IW-1:0] E_I1 = IW'(OB + INV);
  localparam logic [IW-1:0] E_VA = IW'(OB + INV + VALID);
  localparam logic [IW-1:0] LAST = IW'(NPIX - 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP1, S_TG, S_GAP2, S_PIX} st_t;

  st_t           st;
  logic [W-1:0]  cnt;
  logic [IW-1:0] pidx;
  logic [W-1:0]  l_tg, l_gap, l_pix, l_rbw;
  logic          l_mode;

  logic [W-1:0] tg_leg, gap_leg, pix_leg, half, rbw_leg;
  assign tg_leg  = (tg_width   < TGM) ? TGM : tg_width;
  assign gap_leg = (gap_width  < GPM) ? GPM : gap_width;
  assign pix_leg = (pix_period < PXM) ? PXM : pix_period;
  assign half    = {1'b0, pix_leg[W-1:1]};
  assign rbw_leg = (rb_width == '0) ? W'(1) : ((rb_width > half) ? half : rb_width);

  logic pix_end, line_end;
  assign pix_end  = (st == S_PIX) && (cnt == l_pix - 1'b1);
  assign line_end = pix_end && (pidx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      pidx   <= '0;
      l_tg   <= TGM;
      l_gap  <= GPM;
      l_pix  <= PXM;
      l_rbw  <= W'(1);
      l_mode <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if ((st == S_IDLE && run_en) || (line_end && run_en)) begin
        st     <= S_GAP1;
        cnt    <= '0;
        pidx   <= '0;
        l_tg   <= tg_leg;
        l_gap  <= gap_leg;
        l_pix  <= pix_leg;
        l_rbw  <= rbw_leg;
        l_mode <= clamp_mode;
      end else begin
        unique case (st)
          S_IDLE: cnt <= '0;
          S_GAP1: if (cnt == l_gap - 1'b1) begin st <= S_TG;   cnt <= '0; end
          S_TG:   if (cnt == l_tg  - 1'b1) begin st <= S_GAP2; cnt <= '0; end
          S_GAP2: if (cnt == l_gap - 1'b1) begin st <= S_PIX;  cnt <= '0; pidx <= '0; end
          S_PIX: if (pix_end) begin
            cnt <= '0;
            if (line_end) begin st <= S_IDLE; pidx <= '0; end
            else pidx <= pidx + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic       inpix;
  logic [W:0] rb2;
  assign inpix = (st == S_PIX);
  assign rb2   = {l_rbw, 1'b0};

  assign tg    = (st == S_TG);
  assign phi1  = inpix ? pidx[0] : 1'b1;
  assign phi2  = ~phi1;
  assign phi1l = phi1;
  assign phi2l = phi2;
  assign rb    = inpix ? (cnt < l_rbw) : 1'b1;
  assign clb   = l_mode ? ~tg
               : (inpix ? (cnt >= l_rbw && {1'b0, cnt} < rb2) : 1'b1);
  assign line_start = inpix && pidx == '0 && cnt == '0;
  assign pix_idx    = inpix ? pidx : '0;

  always_comb begin
    if (!inpix)              pix_class = 2'b00;
    else if (pidx < E_OB)    pix_class = 2'b01;
    else if (pidx < E_I1)    pix_class = 2'b10;
    else if (pidx < E_VA)    pix_class = 2'b11;
    else                     pix_class = 2'b10;
  end
endmodule

// File: rtl/ccd_timing_chk.sv
module ccd_timing_chk #(
  parameter int TG_MIN = 500,
  parameter int IW     = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          tg,
  input logic          phi1,
  input logic          phi2,
  input logic          phi1l,
  input logic          phi2l,
  input logic          rb,
  input logic          clb,
  input logic          mode,
  input logic          line_start,
  input logic [1:0]    pix_class,
  input logic [IW-1:0] pix_idx
);
  logic [31:0] tg_run;
  always_ff @(posedge clk) begin
    if (rst)     tg_run <= '0;
    else if (tg) tg_run <= tg_run + 1;
    else         tg_run <= '0;
  end

  p_tg_min_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(tg) |-> tg_run >= 32'(TG_MIN));
  p_rb_hold_r6: assert property (@(posedge clk) disable iff (rst)
    tg |-> rb);
  p_clb_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (tg && !mode) |-> clb);
  p_clb_line_r8: assert property (@(posedge clk) disable iff (rst)
    (tg && mode) |-> !clb);
  p_phase_r5: assert property (@(posedge clk) disable iff (rst)
    (phi1 != phi2) && (phi1l == phi1) && (phi2l == phi2));
  p_shift_park_r5: assert property (@(posedge clk) disable iff (rst)
    tg |-> (phi1 && !phi2));
  p_strobe_once_r11: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);
  p_strobe_pos_r11: assert property (@(posedge clk) disable iff (rst)
    line_start |-> (pix_idx == '0 && pix_class == 2'b01 && rb && !phi1));
  p_class_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (pix_class == 2'b00) |-> (pix_idx == '0));
  p_no_tg_in_stream_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_class != 2'b00) |-> !tg);
endmodule

bind ccd_timing_gen ccd_timing_chk #(.TG_MIN(TG_MIN), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .tg(tg), .phi1(phi1), .phi2(phi2), .phi1l(phi1l),
  .phi2l(phi2l), .rb(rb), .clb(clb), .mode(l_mode), .line_start(line_start),
  .pix_class(pix_class), .pix_idx(pix_idx)
);

// File: tb/sim_ccd_timing_gen.sv
`timescale 1ns/1ps
module sim_ccd_timing_gen;
  localparam int W = 8, OB = 3, INV = 2, VALID = 6;
  localparam int TGM = 4, GPM = 3, PXM = 4;
  localparam int N = OB + 2*INV + VALID;
  localparam int IW = $clog2(N);

  logic clk = 0, rst = 1, run_en = 0, clamp_mode = 0;
  logic [W-1:0] tg_width = 0, gap_width = 0, pix_period = 0, rb_width = 0;
  logic tg, phi1, phi2, phi1l, phi2l, rb, clb, line_start;
  logic [1:0] pix_class;
  logic [IW-1:0] pix_idx;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ccd_timing_gen #(.W(W), .OB(OB), .INV(INV), .VALID(VALID),
    .TG_MIN(TGM), .GAP_MIN(GPM), .PIX_MIN(PXM)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .clamp_mode(clamp_mode),
    .tg_width(tg_width), .gap_width(gap_width), .pix_period(pix_period),
    .rb_width(rb_width), .tg(tg), .phi1(phi1), .phi2(phi2), .phi1l(phi1l),
    .phi2l(phi2l), .rb(rb), .clb(clb), .line_start(line_start),
    .pix_class(pix_class), .pix_idx(pix_idx));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic int atleast(int v, int m);
    return (v < m) ? m : v;
  endfunction

  function automatic int rlegal(int r, int p);
    if (r == 0) return 1;
    if (r > p/2) return p/2;
    return r;
  endfunction

  task automatic chk_idle(input string req);
    chk({req, " tg"}, tg, 0);
    chk({req, " rb"}, rb, 1);
    chk({req, " phi"}, {phi1, phi2, phi1l, phi2l}, 4'b1010);
    chk({req, " clb"}, clb, 1);
    chk({req, " strobe"}, line_start, 0);
    chk({req, " class"}, pix_class, 0);
    chk({req, " idx"}, pix_idx, 0);
  endtask

  task automatic drive(input int t, input int g, input int p, input int r, input int m);
    tg_width = W'(t); gap_width = W'(g); pix_period = W'(p); rb_width = W'(r);
    clamp_mode = m[0];
  endtask

  task automatic run(input int ta, input int ga, input int pa, input int ra, input int ma,
                     input int tb, input int gb, input int pb, input int rbb, input int mb,
                     input int nl);
    drive(ta, ga, pa, ra, ma);
    run_en = 1;
    for (int ln = 0; ln < nl; ln++) begin
      int T, G, P, R, M, L;
      T = atleast(ln == 0 ? ta : tb, TGM);
      G = atleast(ln == 0 ? ga : gb, GPM);
      P = atleast(ln == 0 ? pa : pb, PXM);
      R = rlegal(ln == 0 ? ra : rbb, P);
      M = (ln == 0) ? ma : mb;
      L = 2*G + T + N*P;
      for (int t = 0; t < L; t++) begin
        int k, c, ph, e_tg, e_p1, e_rb, e_clb, e_cls, e_idx, e_ls;
        @(negedge clk);
        k = 0; c = 0;
        if (t < G) ph = 0;
        else if (t < G + T) ph = 1;
        else if (t < 2*G + T) ph = 2;
        else begin ph = 3; k = (t - 2*G - T) / P; c = (t - 2*G - T) % P; end
        e_tg  = (ph == 1);
        e_p1  = (ph == 3) ? (k % 2) : 1;
        e_rb  = (ph == 3) ? (c < R) : 1;
        if (M == 1) e_clb = !e_tg;
        else e_clb = (ph == 3) ? (c >= R && c < 2*R) : 1;
        if (ph != 3) e_cls = 0;
        else if (k < OB) e_cls = 1;
        else if (k < OB + INV) e_cls = 2;
        else if (k < OB + INV + VALID) e_cls = 3;
        else e_cls = 2;
        e_idx = (ph == 3) ? k : 0;
        e_ls  = (ph == 3 && k == 0 && c == 0);
        chk("R2 R3 R4 tg", tg, e_tg);
        chk("R5 phi1", phi1, e_p1);
        chk("R5 phi2", phi2, !e_p1);
        chk("R5 last-stage", {phi1l, phi2l}, {phi1, phi2});
        chk("R6 R3 rb", rb, e_rb);
        chk(M == 1 ? "R8 clb" : "R7 clb", clb, e_clb);
        chk("R9 class", pix_class, e_cls);
        chk("R10 idx", pix_idx, e_idx);
        chk("R11 strobe", line_start, e_ls);
        if (ln == 0 && t == 5) drive(tb, gb, pb, rbb, mb);
        if (ln == nl - 1 && t == 0) run_en = 0;
      end
    end
    @(negedge clk);
    chk_idle("R2 stop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk_idle("R1 reset");
    run(6, 4, 6, 2, 0, 6, 4, 6, 2, 0, 2);
    run(7, 5, 5, 2, 1, 7, 5, 5, 2, 1, 2);
    run(1, 0, 2, 0, 0, 1, 0, 2, 0, 0, 1);
    run(5, 3, 7, 9, 1, 5, 3, 7, 9, 1, 1);
    run(6, 4, 6, 2, 0, 4, 3, 5, 1, 1, 3);
    run(4, 3, 8, 4, 0, 9, 6, 4, 0, 0, 2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk_idle("R2 idle hold");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule